// File: doc/BRIEF.md
# Sticky Fault Status and Interrupt Controller

This block watches per-channel health indications for two channel groups: a measurement group of `NUM_MEAS` channels and a stimulus group of `NUM_STIM` channels. Each channel supplies three raw indications: a signal-present flag, an excitation-present flag and a self-test pass flag. A signal or excitation loss only counts as a fault after it has lasted `PERSIST_CYC` consecutive clock cycles. Test failures count at once. The filtered conditions feed six sticky status registers, one per indication kind per group. In these registers a 1 means healthy, and a 0 means a fault was seen since the last read.

A small register port lets the host do three things:
- write the two active-channel masks and the interrupt enable;
- pulse a read strobe that releases a sticky register;
- raise a test-mode input that suspends loss monitoring while an off-line or loopback test runs.

The six fault classes are latched into an interrupt status register, gated by per-class enables. This register drives a level interrupt request.

Top module: `faultStatusIrq`

## Requirements
- R1: After reset, every status register, both active masks, the interrupt enable and the interrupt status are 0, and `irqReq` is 0.
- R2: A status bit reads 1 only for a healthy active channel. One clock edge after a channel's active bit is 0, its bits in all three status registers of its group read 0. Faults on inactive channels never set an interrupt status bit.
- R3: A signal or excitation loss is declared only once the present flag has been sampled low on `PERSIST_CYC` consecutive clock edges. The status bit falls on the following edge. A shorter low pulse has no effect.
- R4: Once a status bit has fallen to 0 it stays 0, even after the condition recovers, until that register is read.
- R5: A read strobe loads each bit of the addressed status register with the channel's present condition. It does not force the bit to 1.
- R6: A test-pass flag sampled low on an active channel clears the matching test status bit at that edge, with no persistence delay.
- R7: While `testMode` is 1, the signal and excitation loss filters of both groups are held clear, so no loss is declared. Test-pass flags are still monitored.
- R8: For an active channel whose two-wire flag is 1, the signal status reads healthy and never raises a signal fault.
- R9: Interrupt status bit k latches when class k has a fault on any active channel and enable bit k is 1. A disabled class never sets its bit. Classes 0 to 5 are: measurement signal loss, measurement excitation loss, measurement test error, stimulus signal loss, stimulus excitation loss, stimulus test error.
- R10: The interrupt status is sticky. Reading it reloads it with the classes that are enabled and still faulty in that cycle, so a class whose fault persists stays set.
- R11: `irqReq` is 1 exactly while some interrupt status bit and its enable bit are both 1. It drops after a read that clears the status, or when the enable is removed.
- R12: Write address 0 sets the measurement active mask, 1 sets the stimulus active mask and 2 sets the interrupt enable, all from the low bits of `wrData`. Read addresses 0 to 5 select the six status registers in class order and 6 selects the interrupt status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| testMode | input | 1 | Suspends signal and excitation loss monitoring |
| measSigOk | input | NUM_MEAS | Raw signal-present flags, measurement group |
| measExcOk | input | NUM_MEAS | Raw excitation-present flags, measurement group |
| measTestOk | input | NUM_MEAS | Self-test pass flags, measurement group |
| measTwoWire | input | NUM_MEAS | Two-wire configuration per measurement channel |
| stimSigOk | input | NUM_STIM | Raw signal-present flags, stimulus group |
| stimExcOk | input | NUM_STIM | Raw excitation-present flags, stimulus group |
| stimTestOk | input | NUM_STIM | Self-test pass flags, stimulus group |
| stimTwoWire | input | NUM_STIM | Two-wire configuration per stimulus channel |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address |
| wrData | input | DATA_W | Write data |
| rdEn | input | 1 | Read strobe, releases the addressed sticky register |
| rdAddr | input | 3 | Read address |
| measSigStat | output | NUM_MEAS | Sticky signal status, measurement group |
| measExcStat | output | NUM_MEAS | Sticky excitation status, measurement group |
| measTestStat | output | NUM_MEAS | Sticky test status, measurement group |
| stimSigStat | output | NUM_STIM | Sticky signal status, stimulus group |
| stimExcStat | output | NUM_STIM | Sticky excitation status, stimulus group |
| stimTestStat | output | NUM_STIM | Sticky test status, stimulus group |
| irqStat | output | 6 | Latched interrupt status per class |
| irqReq | output | 1 | Level interrupt request |

## Verification
The assertions rely on a few assumptions about the inputs:
- all inputs are synchronous to `clk`;
- `rdAddr` and `wrAddr` matter only while their strobes are high;
- `PERSIST_CYC` is at least 1.

The interrupt-hold property also assumes the enable register is not rewritten while a request is pending. Where that is not true, the property excludes the write cycles.

The stimulus respects these assumptions. It changes every input on the falling edge. It uses only the defined addresses. Loss pulses are held either clearly shorter or clearly longer than the persistence window, and recovery waits several cycles before the next read.

// File: rtl/stsPkg.sv
package stsPkg;
  localparam int NUM_SRC = 6;

  typedef enum logic [1:0] {
    WR_MEAS_ACT = 2'd0,
    WR_STIM_ACT = 2'd1,
    WR_IRQ_EN   = 2'd2,
    WR_NONE     = 2'd3
  } wrSel_e;

  typedef enum logic [2:0] {
    RD_MEAS_SIG  = 3'd0,
    RD_MEAS_EXC  = 3'd1,
    RD_MEAS_TEST = 3'd2,
    RD_STIM_SIG  = 3'd3,
    RD_STIM_EXC  = 3'd4,
    RD_STIM_TEST = 3'd5,
    RD_IRQ       = 3'd6,
    RD_NONE      = 3'd7
  } rdSel_e;

  typedef struct packed {
    logic [NUM_SRC-1:0] clrStat;
    logic               clrIrq;
    logic               hold;
  } ctlStrobe_t;
endpackage

// File: rtl/lossFilter.sv
module lossFilter #(
  parameter int PERSIST_CYC = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic rawOk,
  output logic lost
);
  localparam int CW = $clog2(PERSIST_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(PERSIST_CYC);

  logic [CW-1:0] lowCnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              lowCnt <= '0;
    else if (hold || rawOk)  lowCnt <= '0;
    else if (lowCnt != LIMIT) lowCnt <= lowCnt + 1'b1;
  end

  assign lost = (lowCnt == LIMIT);
endmodule

// File: rtl/stsControl.sv
module stsControl
  import stsPkg::*;
#(
  parameter int NM = 8,
  parameter int NS = 6,
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               testMode,
  input  logic               wrEn,
  input  logic [1:0]         wrAddr,
  input  logic [DW-1:0]      wrData,
  input  logic               rdEn,
  input  logic [2:0]         rdAddr,
  output logic [NM-1:0]      measActive,
  output logic [NS-1:0]      stimActive,
  output logic [NUM_SRC-1:0] irqEn,
  output ctlStrobe_t         strobe
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      measActive <= '0;
      stimActive <= '0;
      irqEn      <= '0;
    end else if (wrEn) begin
      case (wrSel_e'(wrAddr))
        WR_MEAS_ACT: measActive <= wrData[NM-1:0];
        WR_STIM_ACT: stimActive <= wrData[NS-1:0];
        WR_IRQ_EN:   irqEn      <= wrData[NUM_SRC-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.hold   = testMode;
    strobe.clrIrq = rdEn && (rdSel_e'(rdAddr) == RD_IRQ);
    for (int k = 0; k < NUM_SRC; k++) begin
      strobe.clrStat[k] = rdEn && (rdAddr == 3'(k));
    end
  end
endmodule

// File: rtl/stsDatapath.sv
module stsDatapath
  import stsPkg::*;
#(
  parameter int NM          = 8,
  parameter int NS          = 6,
  parameter int PERSIST_CYC = 100_000_000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctlStrobe_t         strobe,
  input  logic [NM-1:0]      measActive,
  input  logic [NS-1:0]      stimActive,
  input  logic [NUM_SRC-1:0] irqEn,
  input  logic [NM-1:0]      measSigOk,
  input  logic [NM-1:0]      measExcOk,
  input  logic [NM-1:0]      measTestOk,
  input  logic [NM-1:0]      measTwoWire,
  input  logic [NS-1:0]      stimSigOk,
  input  logic [NS-1:0]      stimExcOk,
  input  logic [NS-1:0]      stimTestOk,
  input  logic [NS-1:0]      stimTwoWire,
  output logic [NM-1:0]      measSigStat,
  output logic [NM-1:0]      measExcStat,
  output logic [NM-1:0]      measTestStat,
  output logic [NS-1:0]      stimSigStat,
  output logic [NS-1:0]      stimExcStat,
  output logic [NS-1:0]      stimTestStat,
  output logic [NUM_SRC-1:0] irqStat,
  output logic               irqReq
);
  logic [NM-1:0] mSigLost, mExcLost;
  logic [NS-1:0] sSigLost, sExcLost;

  for (genvar gm = 0; gm < NM; gm++) begin : gMeasFilt
    lossFilter #(.PERSIST_CYC(PERSIST_CYC)) uSig (
      .clk(clk), .rst_n(rst_n), .hold(strobe.hold),
      .rawOk(measSigOk[gm]), .lost(mSigLost[gm]));
    lossFilter #(.PERSIST_CYC(PERSIST_CYC)) uExc (
      .clk(clk), .rst_n(rst_n), .hold(strobe.hold),
      .rawOk(measExcOk[gm]), .lost(mExcLost[gm]));
  end

  for (genvar gs = 0; gs < NS; gs++) begin : gStimFilt
    lossFilter #(.PERSIST_CYC(PERSIST_CYC)) uSig (
      .clk(clk), .rst_n(rst_n), .hold(strobe.hold),
      .rawOk(stimSigOk[gs]), .lost(sSigLost[gs]));
    lossFilter #(.PERSIST_CYC(PERSIST_CYC)) uExc (
      .clk(clk), .rst_n(rst_n), .hold(strobe.hold),
      .rawOk(stimExcOk[gs]), .lost(sExcLost[gs]));
  end

  // Present-cycle health per channel: active and not faulty
  logic [NM-1:0] goodMSig, goodMExc, goodMTest;
  logic [NS-1:0] goodSSig, goodSExc, goodSTest;

  assign goodMSig  = measActive & (measTwoWire | ~mSigLost);
  assign goodMExc  = measActive & ~mExcLost;
  assign goodMTest = measActive & measTestOk;
  assign goodSSig  = stimActive & (stimTwoWire | ~sSigLost);
  assign goodSExc  = stimActive & ~sExcLost;
  assign goodSTest = stimActive & stimTestOk;

  // A class is faulty when any active channel is unhealthy
  logic [NUM_SRC-1:0] classFault;
  assign classFault[0] = |(measActive & ~goodMSig);
  assign classFault[1] = |(measActive & ~goodMExc);
  assign classFault[2] = |(measActive & ~goodMTest);
  assign classFault[3] = |(stimActive & ~goodSSig);
  assign classFault[4] = |(stimActive & ~goodSExc);
  assign classFault[5] = |(stimActive & ~goodSTest);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      measSigStat  <= '0;
      measExcStat  <= '0;
      measTestStat <= '0;
      stimSigStat  <= '0;
      stimExcStat  <= '0;
      stimTestStat <= '0;
      irqStat      <= '0;
    end else begin
      measSigStat  <= strobe.clrStat[0] ? goodMSig  : (measSigStat  & goodMSig);
      measExcStat  <= strobe.clrStat[1] ? goodMExc  : (measExcStat  & goodMExc);
      measTestStat <= strobe.clrStat[2] ? goodMTest : (measTestStat & goodMTest);
      stimSigStat  <= strobe.clrStat[3] ? goodSSig  : (stimSigStat  & goodSSig);
      stimExcStat  <= strobe.clrStat[4] ? goodSExc  : (stimExcStat  & goodSExc);
      stimTestStat <= strobe.clrStat[5] ? goodSTest : (stimTestStat & goodSTest);
      irqStat      <= strobe.clrIrq ? (classFault & irqEn)
                                    : (irqStat | (classFault & irqEn));
    end
  end

  assign irqReq = |(irqStat & irqEn);
endmodule

// File: rtl/faultStatusIrq.sv
module faultStatusIrq
  import stsPkg::*;
#(
  parameter int NUM_MEAS    = 8,
  parameter int NUM_STIM    = 6,
  parameter int PERSIST_CYC = 100_000_000,
  localparam int WIDE_CH    = (NUM_MEAS > NUM_STIM) ? NUM_MEAS : NUM_STIM,
  localparam int DATA_W     = (WIDE_CH > NUM_SRC) ? WIDE_CH : NUM_SRC
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                testMode,
  input  logic [NUM_MEAS-1:0] measSigOk,
  input  logic [NUM_MEAS-1:0] measExcOk,
  input  logic [NUM_MEAS-1:0] measTestOk,
  input  logic [NUM_MEAS-1:0] measTwoWire,
  input  logic [NUM_STIM-1:0] stimSigOk,
  input  logic [NUM_STIM-1:0] stimExcOk,
  input  logic [NUM_STIM-1:0] stimTestOk,
  input  logic [NUM_STIM-1:0] stimTwoWire,
  input  logic                wrEn,
  input  logic [1:0]          wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                rdEn,
  input  logic [2:0]          rdAddr,
  output logic [NUM_MEAS-1:0] measSigStat,
  output logic [NUM_MEAS-1:0] measExcStat,
  output logic [NUM_MEAS-1:0] measTestStat,
  output logic [NUM_STIM-1:0] stimSigStat,
  output logic [NUM_STIM-1:0] stimExcStat,
  output logic [NUM_STIM-1:0] stimTestStat,
  output logic [NUM_SRC-1:0]  irqStat,
  output logic                irqReq
);
  logic [NUM_MEAS-1:0] measActive;
  logic [NUM_STIM-1:0] stimActive;
  logic [NUM_SRC-1:0]  irqEn;
  ctlStrobe_t          strobe;

  stsControl #(.NM(NUM_MEAS), .NS(NUM_STIM), .DW(DATA_W)) uCtl (
    .clk(clk), .rst_n(rst_n), .testMode(testMode),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr),
    .measActive(measActive), .stimActive(stimActive),
    .irqEn(irqEn), .strobe(strobe));

  stsDatapath #(.NM(NUM_MEAS), .NS(NUM_STIM), .PERSIST_CYC(PERSIST_CYC)) uDp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .measActive(measActive), .stimActive(stimActive), .irqEn(irqEn),
    .measSigOk(measSigOk), .measExcOk(measExcOk),
    .measTestOk(measTestOk), .measTwoWire(measTwoWire),
    .stimSigOk(stimSigOk), .stimExcOk(stimExcOk),
    .stimTestOk(stimTestOk), .stimTwoWire(stimTwoWire),
    .measSigStat(measSigStat), .measExcStat(measExcStat),
    .measTestStat(measTestStat), .stimSigStat(stimSigStat),
    .stimExcStat(stimExcStat), .stimTestStat(stimTestStat),
    .irqStat(irqStat), .irqReq(irqReq));
endmodule

// File: rtl/stsChecker.sv
module stsChecker #(
  parameter int NM = 8,
  parameter int NS = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          testMode,
  input logic          wrEn,
  input logic          rdEn,
  input logic [2:0]    rdAddr,
  input logic [NM-1:0] measActive,
  input logic [NS-1:0] stimActive,
  input logic [NM-1:0] measTwoWire,
  input logic [NS-1:0] stimTwoWire,
  input logic [5:0]    irqEn,
  input logic [NM-1:0] measSigStat,
  input logic [NM-1:0] measExcStat,
  input logic [NM-1:0] measTestStat,
  input logic [NS-1:0] stimSigStat,
  input logic [NS-1:0] stimExcStat,
  input logic [5:0]    irqStat,
  input logic          irqReq
);
  AST_INACTIVE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (((measSigStat | measExcStat | measTestStat) & ~$past(measActive)) == '0)); // R2

  AST_STICKY_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rdEn && rdAddr == 3'd0) |=> ((measSigStat & ~$past(measSigStat)) == '0)); // R4

  AST_STICKY_NO_RISE_STIM: assert property (@(posedge clk) disable iff (!rst_n)
    !(rdEn && rdAddr == 3'd4) |=> ((stimExcStat & ~$past(stimExcStat)) == '0)); // R4

  AST_HOLD_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (testMode && $past(testMode)) |=>
      ((~measExcStat & $past(measExcStat) & $past(measActive)) == '0)); // R7

  AST_TWO_WIRE_SIG: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((~stimSigStat & $past(stimSigStat) & $past(stimActive & stimTwoWire)) == '0)); // R8

  AST_TWO_WIRE_SIG_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((~measSigStat & $past(measSigStat) & $past(measActive & measTwoWire)) == '0)); // R8

  AST_IRQ_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((irqStat & ~$past(irqStat) & ~$past(irqEn)) == '0)); // R9

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irqReq && !(rdEn && rdAddr == 3'd6) && !wrEn) |=> irqReq); // R11
endmodule

bind faultStatusIrq stsChecker #(.NM(NUM_MEAS), .NS(NUM_STIM)) uChk (
  .clk(clk), .rst_n(rst_n), .testMode(testMode), .wrEn(wrEn),
  .rdEn(rdEn), .rdAddr(rdAddr),
  .measActive(measActive), .stimActive(stimActive),
  .measTwoWire(measTwoWire), .stimTwoWire(stimTwoWire), .irqEn(irqEn),
  .measSigStat(measSigStat), .measExcStat(measExcStat),
  .measTestStat(measTestStat), .stimSigStat(stimSigStat),
  .stimExcStat(stimExcStat), .irqStat(irqStat), .irqReq(irqReq));

// File: tb/sim_faultStatusIrq.sv
`timescale 1ns/1ps
module sim_faultStatusIrq;
  localparam int NM = 8;
  localparam int NS = 6;
  localparam int P  = 6;

  logic clk = 0, rst_n = 0, testMode = 0;
  logic [NM-1:0] measSigOk = '1, measExcOk = '1, measTestOk = '1, measTwoWire = '0;
  logic [NS-1:0] stimSigOk = '1, stimExcOk = '1, stimTestOk = '1, stimTwoWire = '0;
  logic wrEn = 0, rdEn = 0;
  logic [1:0] wrAddr = 0;
  logic [7:0] wrData = 0;
  logic [2:0] rdAddr = 0;
  logic [NM-1:0] measSigStat, measExcStat, measTestStat;
  logic [NS-1:0] stimSigStat, stimExcStat, stimTestStat;
  logic [5:0] irqStat;
  logic irqReq;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  faultStatusIrq #(.NUM_MEAS(NM), .NUM_STIM(NS), .PERSIST_CYC(P)) u0 (.*);

  // Behavioural reference model
  logic [NM-1:0] xMs, xMe, xMt, mAct;
  logic [NS-1:0] xSs, xSe, xSt, sAct;
  logic [5:0] xEn, xIrq;
  int cMs[NM], cMe[NM], cSs[NS], cSe[NS];

  always @(posedge clk) begin : model
    logic [NM-1:0] gMs, gMe, gMt;
    logic [NS-1:0] gSs, gSe, gSt;
    logic [5:0] flt;
    if (!rst_n) begin
      xMs = 0; xMe = 0; xMt = 0; mAct = 0;
      xSs = 0; xSe = 0; xSt = 0; sAct = 0;
      xEn = 0; xIrq = 0;
      for (int i = 0; i < NM; i++) begin cMs[i] = 0; cMe[i] = 0; end
      for (int i = 0; i < NS; i++) begin cSs[i] = 0; cSe[i] = 0; end
    end else begin
      for (int i = 0; i < NM; i++) begin
        gMs[i] = mAct[i] && (measTwoWire[i] || cMs[i] < P);
        gMe[i] = mAct[i] && (cMe[i] < P);
        gMt[i] = mAct[i] && measTestOk[i];
      end
      for (int i = 0; i < NS; i++) begin
        gSs[i] = sAct[i] && (stimTwoWire[i] || cSs[i] < P);
        gSe[i] = sAct[i] && (cSe[i] < P);
        gSt[i] = sAct[i] && stimTestOk[i];
      end
      flt = {|(sAct & ~gSt), |(sAct & ~gSe), |(sAct & ~gSs),
             |(mAct & ~gMt), |(mAct & ~gMe), |(mAct & ~gMs)};
      xMs = (rdEn && rdAddr == 0) ? gMs : (xMs & gMs);
      xMe = (rdEn && rdAddr == 1) ? gMe : (xMe & gMe);
      xMt = (rdEn && rdAddr == 2) ? gMt : (xMt & gMt);
      xSs = (rdEn && rdAddr == 3) ? gSs : (xSs & gSs);
      xSe = (rdEn && rdAddr == 4) ? gSe : (xSe & gSe);
      xSt = (rdEn && rdAddr == 5) ? gSt : (xSt & gSt);
      xIrq = (rdEn && rdAddr == 6) ? (flt & xEn) : (xIrq | (flt & xEn));
      for (int i = 0; i < NM; i++) begin
        cMs[i] = (testMode || measSigOk[i]) ? 0 : ((cMs[i] < P) ? cMs[i] + 1 : P);
        cMe[i] = (testMode || measExcOk[i]) ? 0 : ((cMe[i] < P) ? cMe[i] + 1 : P);
      end
      for (int i = 0; i < NS; i++) begin
        cSs[i] = (testMode || stimSigOk[i]) ? 0 : ((cSs[i] < P) ? cSs[i] + 1 : P);
        cSe[i] = (testMode || stimExcOk[i]) ? 0 : ((cSe[i] < P) ? cSe[i] + 1 : P);
      end
      if (wrEn) begin
        case (wrAddr)
          2'd0: mAct = wrData[NM-1:0];
          2'd1: sAct = wrData[NS-1:0];
          2'd2: xEn  = wrData[5:0];
          default: ;
        endcase
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R4 measSig vs model",  32'(measSigStat),  32'(xMs));
      check("R4 measExc vs model",  32'(measExcStat),  32'(xMe));
      check("R6 measTest vs model", 32'(measTestStat), 32'(xMt));
      check("R4 stimSig vs model",  32'(stimSigStat),  32'(xSs));
      check("R4 stimExc vs model",  32'(stimExcStat),  32'(xSe));
      check("R6 stimTest vs model", 32'(stimTestStat), 32'(xSt));
      check("R10 irqStat vs model", 32'(irqStat),      32'(xIrq));
      check("R11 irqReq vs model",  32'(irqReq),       32'(|(xIrq & xEn)));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rdReg(logic [2:0] a);
    @(negedge clk); rdEn = 1; rdAddr = a;
    @(negedge clk); rdEn = 0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL R1 watchdog expired: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1;
    idle(1);
    // R1 reset state
    check("R1 status after reset", 32'({measSigStat, measExcStat, measTestStat,
          stimSigStat, stimExcStat, stimTestStat}), 0);
    check("R1 irq after reset", 32'({irqStat, irqReq}), 0);

    // R12 register map and R5 arming reads
    wrReg(2'd0, 8'hFF); wrReg(2'd1, 8'h3F); wrReg(2'd2, 8'h3F);
    for (int a = 0; a < 7; a++) rdReg(3'(a));
    check("R12 measSig after arm", 32'(measSigStat), 32'hFF);
    check("R12 stimTest after arm", 32'(stimTestStat), 32'h3F);
    check("R5 measExc after arm", 32'(measExcStat), 32'hFF);

    // R3 short loss ignored
    @(negedge clk); measExcOk[2] = 0;
    idle(P - 1); measExcOk[2] = 1;
    idle(2);
    check("R3 short loss ignored", 32'(measExcStat), 32'hFF);
    // R3 long loss declared
    measExcOk[2] = 0;
    idle(P + 2);
    check("R3 long loss latched", 32'(measExcStat), 32'hFB);
    check("R9 irq class 1", 32'(irqStat), 32'h02);
    check("R11 irqReq raised", 32'(irqReq), 1);
    measExcOk[2] = 1;
    idle(3);
    check("R4 stays latched after recovery", 32'(measExcStat), 32'hFB);
    rdReg(3'd1);
    check("R5 read reloads healthy", 32'(measExcStat), 32'hFF);
    check("R10 irq still latched", 32'(irqStat), 32'h02);
    rdReg(3'd6);
    check("R10 irq cleared by read", 32'(irqStat), 0);
    check("R11 irqReq dropped", 32'(irqReq), 0);

    // R6 one-cycle test failure
    stimTestOk[4] = 0; idle(1); stimTestOk[4] = 1; idle(1);
    check("R6 stim test fault", 32'(stimTestStat), 32'h2F);
    check("R9 irq class 5", 32'(irqStat), 32'h20);
    rdReg(3'd5); rdReg(3'd6);

    // R7 test mode suspends loss monitoring
    testMode = 1; idle(1);
    measSigOk[0] = 0; idle(3 * P);
    check("R7 no loss in test mode", 32'(measSigStat), 32'hFF);
    measTestOk[3] = 0; idle(1); measTestOk[3] = 1; idle(1);
    check("R7 test flags still watched", 32'(measTestStat), 32'hF7);
    measSigOk[0] = 1; idle(2); testMode = 0; idle(2);
    rdReg(3'd2); rdReg(3'd6);
    check("R12 read addr 2 releases test", 32'(measTestStat), 32'hFF);

    // R8 two-wire signal not monitored
    measTwoWire = 8'h20; idle(1);
    measSigOk[5] = 0; idle(2 * P);
    check("R8 two-wire sig healthy", 32'(measSigStat), 32'hFF);
    check("R8 no irq for two-wire", 32'(irqStat), 0);
    measSigOk[5] = 1; idle(2);

    // R9 disabled class never latches
    wrReg(2'd2, 8'h3E);
    measSigOk[1] = 0; idle(2 * P);
    check("R9 status still tracks", 32'(measSigStat), 32'hFD);
    check("R9 disabled class no irq", 32'({irqStat, irqReq}), 0);
    measSigOk[1] = 1; idle(3);
    rdReg(3'd0); wrReg(2'd2, 8'h3F);

    // R2 inactive channels read zero
    wrReg(2'd0, 8'h0F); idle(1);
    check("R2 inactive sig zero", 32'(measSigStat), 32'h0F);
    check("R2 inactive exc zero", 32'(measExcStat), 32'h0F);
    measExcOk[6] = 0; idle(2 * P);
    check("R2 inactive fault no irq", 32'(irqStat), 0);
    measExcOk[6] = 1; idle(2);

    // R10 persisting fault survives read
    stimExcOk[0] = 0; idle(2 * P);
    check("R3 stim exc loss", 32'(stimExcStat), 32'h3E);
    rdReg(3'd6);
    check("R10 persisting fault kept", 32'(irqStat), 32'h10);
    check("R11 irqReq held", 32'(irqReq), 1);
    stimExcOk[0] = 1; idle(3);
    rdReg(3'd6);
    check("R11 irqReq after clear", 32'({irqStat, irqReq}), 0);
    rdReg(3'd4);
    check("R5 stim exc reload", 32'(stimExcStat), 32'h3F);

    // R11 enable removal masks request
    stimTestOk[0] = 0; idle(1); stimTestOk[0] = 1; idle(1);
    check("R11 irqReq on test error", 32'(irqReq), 1);
    wrReg(2'd2, 8'h1F);
    check("R11 status kept when masked", 32'(irqStat), 32'h20);
    check("R11 request masked", 32'(irqReq), 0);

    idle(2);
    done = 1;
    summary();
    $finish;
  end
endmodule